// File: doc/BRIEF.md
# Legacy Keyboard Controller Register Emulation

This block stands in for the status and data registers of a classic PC keyboard/mouse controller inside a USB host controller. Two sides reach it. On one side is a simple legacy I/O-port bus, where software writes command bytes to port 64h and data bytes to port 60h, reads keyboard or mouse data from port 60h and reads the status byte from port 64h. On the other side is the host-controller firmware, which reaches three 32-bit registers: the captured input byte, the output byte and the status byte.

Legacy port accesses update the status flags directly. The flags then drive the two legacy interrupt lines, one for the keyboard and one for the auxiliary device. They also drive an emulation interrupt that tells the firmware there is work to do. The block recognises the two-write sequence that programs the address-line-20 gate, and it drives a gate output without flagging that sequence as pending input. The control inputs for interrupt enable, emulation enable and character pending come from a control register elsewhere.

Top module: `kbd_emu_top`

## Requirements
- R1: After reset, the status byte, the input byte, the output byte, the gate output and all three interrupt outputs are 0.
- R2: A firmware read at offset 104h returns the input byte, at 108h the output byte and at 10Ch the status byte, each in bits 7:0 with bits 31:8 zero. Any other offset reads 0.
- R3: A legacy write to port 60h or 64h stores the written byte in the input byte. A firmware write to 104h and a legacy write to any other port leave the input byte unchanged.
- R4: The command/data flag is status bit 3. A legacy write to port 60h clears it and a legacy write to port 64h sets it.
- R5: The input-full flag is status bit 1. It is set by every legacy write to port 60h or 64h, except the two writes of a gate sequence.
- R6: A write of D1h to port 64h arms a gate sequence, and the next write to port 60h completes it. That data write loads the gate output from bit 1 of its byte, and neither write changes input-full. A write to port 64h with any other value disarms the sequence.
- R7: A legacy read of port 60h returns the output byte and clears the output-full flag, which is status bit 0. A legacy read of port 64h returns the status byte and changes nothing.
- R8: A firmware write to 108h loads the output byte and leaves output-full unchanged. A firmware write to 10Ch loads the whole status byte.
- R9: The keyboard interrupt is high exactly when the interrupt enable is set, output-full is 1 and the auxiliary-full flag (status bit 5) is 0.
- R10: The auxiliary interrupt is high exactly when the interrupt enable is set, output-full is 1 and auxiliary-full is 1. The two interrupts are never high together.
- R11: The emulation interrupt is high when emulation is enabled and input-full is 1. It is also high when output-full is 0 and character-pending is 1.
- R12: When a legacy access and a firmware status write fall in the same cycle, the legacy update wins for the bits it affects (command/data, input-full, output-full). The firmware value holds for the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fwAddr | input | 12 | Firmware register offset |
| fwWrEn | input | 1 | Firmware write strobe |
| fwWrData | input | 32 | Firmware write data |
| fwRdData | output | 32 | Firmware read data for fwAddr |
| ioAddr | input | 8 | Legacy port number |
| ioWrEn | input | 1 | Legacy write strobe |
| ioRdEn | input | 1 | Legacy read strobe |
| ioWrData | input | 8 | Legacy write byte |
| ioRdData | output | 8 | Legacy read byte |
| irqEnable | input | 1 | Legacy interrupt enable |
| emuEnable | input | 1 | Emulation enable |
| charPending | input | 1 | Firmware has a character waiting |
| irq1 | output | 1 | Keyboard interrupt |
| irq12 | output | 1 | Auxiliary-device interrupt |
| emuIrq | output | 1 | Emulation interrupt to firmware |
| gateA20 | output | 1 | Address-line-20 gate |

## Verification
The hardest case to reach is a firmware status write in the same cycle as a legacy access. A directed task drives both strobes on one clock edge, once for a port-60h read against a status write of FFh and once for a port-64h write against a status write of 00h. The gate sequence also needs a set order of accesses. The bench arms it, completes it, and then arms it and breaks it with a different command before the data write, to show that the disarmed data write sets input-full and does not move the gate.

// File: rtl/kbd_emu_pkg.sv
package kbd_emu_pkg;

  localparam int ST_PARITY  = 7;
  localparam int ST_TIMEOUT = 6;
  localparam int ST_AUXFULL = 5;
  localparam int ST_INHIBIT = 4;
  localparam int ST_CMDDATA = 3;
  localparam int ST_FLAG    = 2;
  localparam int ST_INFULL  = 1;
  localparam int ST_OUTFULL = 0;

  typedef struct packed {
    logic ldInput;
    logic setCmd;
    logic clrCmd;
    logic setInFull;
    logic clrOutFull;
    logic ldStatus;
    logic ldOutput;
    logic ldGate;
    logic selStatus;
  } strobe_t;

endpackage

// File: rtl/kbd_emu_ctrl.sv
module kbd_emu_ctrl
  import kbd_emu_pkg::*;
#(
  parameter int FW_ADDR_W = 12,
  parameter int IO_ADDR_W = 8,
  parameter int BYTE_W    = 8,
  parameter logic [IO_ADDR_W-1:0] DATA_PORT = 8'h60,
  parameter logic [IO_ADDR_W-1:0] CMD_PORT  = 8'h64,
  parameter logic [FW_ADDR_W-1:0] OUT_OFS   = 12'h108,
  parameter logic [FW_ADDR_W-1:0] STAT_OFS  = 12'h10C,
  parameter logic [BYTE_W-1:0]    GATE_CMD  = 8'hD1
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [FW_ADDR_W-1:0] fwAddr,
  input  logic                 fwWrEn,
  input  logic [IO_ADDR_W-1:0] ioAddr,
  input  logic                 ioWrEn,
  input  logic                 ioRdEn,
  input  logic [BYTE_W-1:0]    ioWrData,
  output strobe_t              strobes
);

  logic armedQ;
  logic hitData, hitCmd;
  logic wrData, wrCmd;
  logic startGate, finishGate;

  assign hitData    = (ioAddr == DATA_PORT);
  assign hitCmd     = (ioAddr == CMD_PORT);
  assign wrData     = ioWrEn && hitData;
  assign wrCmd      = ioWrEn && hitCmd;
  assign startGate  = wrCmd && (ioWrData == GATE_CMD);
  assign finishGate = wrData && armedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      armedQ <= 1'b0;
    else if (wrCmd) armedQ <= startGate;
    else if (wrData) armedQ <= 1'b0;
  end

  always_comb begin
    strobes            = '0;
    strobes.ldInput    = wrData || wrCmd;
    strobes.clrCmd     = wrData;
    strobes.setCmd     = wrCmd;
    strobes.setInFull  = (wrData || wrCmd) && !startGate && !finishGate;
    strobes.clrOutFull = ioRdEn && hitData;
    strobes.ldStatus   = fwWrEn && (fwAddr == STAT_OFS);
    strobes.ldOutput   = fwWrEn && (fwAddr == OUT_OFS);
    strobes.ldGate     = finishGate;
    strobes.selStatus  = hitCmd;
  end

endmodule

// File: rtl/kbd_emu_dp.sv
module kbd_emu_dp
  import kbd_emu_pkg::*;
#(
  parameter int FW_ADDR_W = 12,
  parameter int FW_DATA_W = 32,
  parameter int BYTE_W    = 8,
  parameter logic [FW_ADDR_W-1:0] IN_OFS   = 12'h104,
  parameter logic [FW_ADDR_W-1:0] OUT_OFS  = 12'h108,
  parameter logic [FW_ADDR_W-1:0] STAT_OFS = 12'h10C
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [FW_ADDR_W-1:0] fwAddr,
  input  logic [FW_DATA_W-1:0] fwWrData,
  input  logic [BYTE_W-1:0]    ioWrData,
  input  logic                 irqEnable,
  input  logic                 emuEnable,
  input  logic                 charPending,
  output logic [FW_DATA_W-1:0] fwRdData,
  output logic [BYTE_W-1:0]    ioRdData,
  output logic [BYTE_W-1:0]    statusByte,
  output logic                 irq1,
  output logic                 irq12,
  output logic                 emuIrq,
  output logic                 gateA20
);

  localparam int PAD_W = FW_DATA_W - BYTE_W;

  logic [BYTE_W-1:0] inputQ, outputQ, statusQ, statusD;
  logic              gateQ;

  always_comb begin
    statusD = strobes.ldStatus ? fwWrData[BYTE_W-1:0] : statusQ;
    if (strobes.clrCmd)     statusD[ST_CMDDATA] = 1'b0;
    if (strobes.setCmd)     statusD[ST_CMDDATA] = 1'b1;
    if (strobes.setInFull)  statusD[ST_INFULL]  = 1'b1;
    if (strobes.clrOutFull) statusD[ST_OUTFULL] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inputQ  <= '0;
      outputQ <= '0;
      statusQ <= '0;
      gateQ   <= 1'b0;
    end else begin
      statusQ <= statusD;
      if (strobes.ldInput)  inputQ  <= ioWrData;
      if (strobes.ldOutput) outputQ <= fwWrData[BYTE_W-1:0];
      if (strobes.ldGate)   gateQ   <= ioWrData[1];
    end
  end

  always_comb begin
    unique case (fwAddr)
      IN_OFS:   fwRdData = {{PAD_W{1'b0}}, inputQ};
      OUT_OFS:  fwRdData = {{PAD_W{1'b0}}, outputQ};
      STAT_OFS: fwRdData = {{PAD_W{1'b0}}, statusQ};
      default:  fwRdData = '0;
    endcase
  end

  assign ioRdData   = strobes.selStatus ? statusQ : outputQ;
  assign statusByte = statusQ;
  assign gateA20    = gateQ;
  assign irq1       = irqEnable && statusQ[ST_OUTFULL] && !statusQ[ST_AUXFULL];
  assign irq12      = irqEnable && statusQ[ST_OUTFULL] &&  statusQ[ST_AUXFULL];
  assign emuIrq     = (emuEnable && statusQ[ST_INFULL]) ||
                      (!statusQ[ST_OUTFULL] && charPending);

endmodule

// File: rtl/kbd_emu_top.sv
module kbd_emu_top
  import kbd_emu_pkg::*;
#(
  parameter int FW_ADDR_W = 12,
  parameter int FW_DATA_W = 32,
  parameter int IO_ADDR_W = 8,
  parameter int BYTE_W    = 8,
  parameter logic [IO_ADDR_W-1:0] DATA_PORT = 8'h60,
  parameter logic [IO_ADDR_W-1:0] CMD_PORT  = 8'h64,
  parameter logic [FW_ADDR_W-1:0] IN_OFS    = 12'h104,
  parameter logic [FW_ADDR_W-1:0] OUT_OFS   = 12'h108,
  parameter logic [FW_ADDR_W-1:0] STAT_OFS  = 12'h10C,
  parameter logic [BYTE_W-1:0]    GATE_CMD  = 8'hD1
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [FW_ADDR_W-1:0] fwAddr,
  input  logic                 fwWrEn,
  input  logic [FW_DATA_W-1:0] fwWrData,
  output logic [FW_DATA_W-1:0] fwRdData,
  input  logic [IO_ADDR_W-1:0] ioAddr,
  input  logic                 ioWrEn,
  input  logic                 ioRdEn,
  input  logic [BYTE_W-1:0]    ioWrData,
  output logic [BYTE_W-1:0]    ioRdData,
  input  logic                 irqEnable,
  input  logic                 emuEnable,
  input  logic                 charPending,
  output logic                 irq1,
  output logic                 irq12,
  output logic                 emuIrq,
  output logic                 gateA20
);

  strobe_t           strobes;
  logic [BYTE_W-1:0] statusByte;

  kbd_emu_ctrl #(
    .FW_ADDR_W(FW_ADDR_W), .IO_ADDR_W(IO_ADDR_W), .BYTE_W(BYTE_W),
    .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT),
    .OUT_OFS(OUT_OFS), .STAT_OFS(STAT_OFS), .GATE_CMD(GATE_CMD)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .fwAddr(fwAddr), .fwWrEn(fwWrEn),
    .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioWrData(ioWrData), .strobes(strobes)
  );

  kbd_emu_dp #(
    .FW_ADDR_W(FW_ADDR_W), .FW_DATA_W(FW_DATA_W), .BYTE_W(BYTE_W),
    .IN_OFS(IN_OFS), .OUT_OFS(OUT_OFS), .STAT_OFS(STAT_OFS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fwAddr(fwAddr),
    .fwWrData(fwWrData), .ioWrData(ioWrData), .irqEnable(irqEnable),
    .emuEnable(emuEnable), .charPending(charPending),
    .fwRdData(fwRdData), .ioRdData(ioRdData), .statusByte(statusByte),
    .irq1(irq1), .irq12(irq12), .emuIrq(emuIrq), .gateA20(gateA20)
  );

endmodule

// File: rtl/kbd_emu_chk.sv
module kbd_emu_chk #(
  parameter int FW_DATA_W = 32,
  parameter int IO_ADDR_W = 8,
  parameter int BYTE_W    = 8,
  parameter logic [IO_ADDR_W-1:0] DATA_PORT = 8'h60,
  parameter logic [IO_ADDR_W-1:0] CMD_PORT  = 8'h64
)(
  input logic                 clk,
  input logic                 rstN,
  input logic [IO_ADDR_W-1:0] ioAddr,
  input logic                 ioWrEn,
  input logic                 ioRdEn,
  input logic                 irqEnable,
  input logic                 emuEnable,
  input logic                 irq1,
  input logic                 irq12,
  input logic                 emuIrq,
  input logic [FW_DATA_W-1:0] fwRdData,
  input logic [BYTE_W-1:0]    statusByte
);

  assert_cmd_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioAddr == DATA_PORT) |=> !statusByte[3]);

  assert_cmd_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioAddr == CMD_PORT) |=> statusByte[3]);

  assert_outfull_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ioRdEn && ioAddr == DATA_PORT) |=> !statusByte[0]);

  assert_irq_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(irq1 && irq12));

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irq1 || irq12) |-> (irqEnable && statusByte[0]));

  assert_emu_on_input_R11: assert property (@(posedge clk) disable iff (!rstN)
    (emuEnable && statusByte[1]) |-> emuIrq);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    fwRdData[FW_DATA_W-1:BYTE_W] == '0);

endmodule

bind kbd_emu_top kbd_emu_chk #(
  .FW_DATA_W(FW_DATA_W), .IO_ADDR_W(IO_ADDR_W), .BYTE_W(BYTE_W),
  .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
) chk_i (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
  .irqEnable(irqEnable), .emuEnable(emuEnable), .irq1(irq1), .irq12(irq12),
  .emuIrq(emuIrq), .fwRdData(fwRdData), .statusByte(statusByte)
);

// File: tb/kbd_emu_top_tb_top.sv
module kbd_emu_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] fwAddr = '0;
  logic        fwWrEn = 1'b0;
  logic [31:0] fwWrData = '0;
  logic [31:0] fwRdData;
  logic [7:0]  ioAddr = '0;
  logic        ioWrEn = 1'b0;
  logic        ioRdEn = 1'b0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic        irqEnable = 1'b0;
  logic        emuEnable = 1'b0;
  logic        charPending = 1'b0;
  logic        irq1, irq12, emuIrq, gateA20;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_emu_top dut_i (
    .clk(clk), .rstN(rstN), .fwAddr(fwAddr), .fwWrEn(fwWrEn),
    .fwWrData(fwWrData), .fwRdData(fwRdData), .ioAddr(ioAddr),
    .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .irqEnable(irqEnable), .emuEnable(emuEnable),
    .charPending(charPending), .irq1(irq1), .irq12(irq12),
    .emuIrq(emuIrq), .gateA20(gateA20)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fwPeek(input logic [11:0] ofs);
    fwAddr = ofs;
    return 32'h0;
  endfunction

  task automatic fwRead(input string tag, input logic [11:0] ofs, input logic [31:0] exp);
    logic [31:0] dummy;
    dummy = fwPeek(ofs);
    #1;
    check(tag, fwRdData, exp);
  endtask

  task automatic ioWrite(input logic [7:0] port, input logic [7:0] data);
    @(negedge clk);
    ioAddr = port; ioWrData = data; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic fwWrite(input logic [11:0] ofs, input logic [31:0] data);
    @(negedge clk);
    fwAddr = ofs; fwWrData = data; fwWrEn = 1'b1;
    @(negedge clk);
    fwWrEn = 1'b0;
  endtask

  task automatic ioRead(input string tag, input logic [7:0] port, input logic [7:0] exp);
    @(negedge clk);
    ioAddr = port; ioRdEn = 1'b1;
    #1;
    check(tag, {24'h0, ioRdData}, {24'h0, exp});
    @(negedge clk);
    ioRdEn = 1'b0;
  endtask

  task automatic testReset();
    fwRead("R1 status", 12'h10C, 32'h0);
    fwRead("R1 input",  12'h104, 32'h0);
    fwRead("R1 output", 12'h108, 32'h0);
    check("R1 outputs", {28'h0, irq1, irq12, emuIrq, gateA20}, 32'h0);
  endtask

  task automatic testPortWrites();
    ioWrite(8'h60, 8'h5A);
    fwRead("R3 input after 60h", 12'h104, 32'h5A);
    fwRead("R4 R5 status after 60h", 12'h10C, 32'h02);
    ioWrite(8'h64, 8'h20);
    fwRead("R3 input after 64h", 12'h104, 32'h20);
    fwRead("R4 status after 64h", 12'h10C, 32'h0A);
    fwWrite(12'h104, 32'hFFFF_FFFF);
    fwRead("R3 fw write ignored", 12'h104, 32'h20);
    ioWrite(8'h61, 8'h77);
    fwRead("R3 other port ignored", 12'h104, 32'h20);
    fwRead("R2 unmapped offset", 12'h100, 32'h0);
  endtask

  task automatic testOutputPath();
    irqEnable = 1'b1;
    fwWrite(12'h108, 32'hABCD_001C);
    fwRead("R8 output load", 12'h108, 32'h1C);
    fwRead("R8 outfull unchanged", 12'h10C, 32'h0A);
    fwWrite(12'h10C, 32'h01);
    fwRead("R8 status load", 12'h10C, 32'h01);
    check("R9 irq1 on", {30'h0, irq1, irq12}, 32'h2);
    ioRead("R7 read 60h data", 8'h60, 8'h1C);
    fwRead("R7 outfull cleared", 12'h10C, 32'h00);
    check("R9 irq1 off", {30'h0, irq1, irq12}, 32'h0);
  endtask

  task automatic testAuxIrq();
    fwWrite(12'h10C, 32'h21);
    #1;
    check("R10 irq12 on", {30'h0, irq1, irq12}, 32'h1);
    irqEnable = 1'b0;
    #1;
    check("R9 R10 disabled", {30'h0, irq1, irq12}, 32'h0);
  endtask

  task automatic testEmuIrq();
    fwWrite(12'h10C, 32'h03);
    emuEnable = 1'b1;
    #1;
    check("R11 input full", {31'h0, emuIrq}, 32'h1);
    emuEnable = 1'b0;
    #1;
    check("R11 disabled", {31'h0, emuIrq}, 32'h0);
    fwWrite(12'h10C, 32'h00);
    charPending = 1'b1;
    #1;
    check("R11 char pending", {31'h0, emuIrq}, 32'h1);
    fwWrite(12'h10C, 32'h01);
    #1;
    check("R11 outfull blocks", {31'h0, emuIrq}, 32'h0);
    charPending = 1'b0;
  endtask

  task automatic testGate();
    fwWrite(12'h10C, 32'h00);
    ioWrite(8'h64, 8'hD1);
    fwRead("R6 arm no infull", 12'h10C, 32'h08);
    fwRead("R3 D1 captured", 12'h104, 32'hD1);
    ioWrite(8'h60, 8'h02);
    fwRead("R6 data no infull", 12'h10C, 32'h00);
    check("R6 gate set", {31'h0, gateA20}, 32'h1);
    ioWrite(8'h64, 8'hD1);
    ioWrite(8'h64, 8'h10);
    fwRead("R5 disarm sets infull", 12'h10C, 32'h0A);
    ioWrite(8'h60, 8'h00);
    check("R6 gate held", {31'h0, gateA20}, 32'h1);
    fwRead("R5 plain data write", 12'h10C, 32'h02);
  endtask

  task automatic testCmdRead();
    fwWrite(12'h10C, 32'h05);
    ioRead("R7 read 64h status", 8'h64, 8'h05);
    fwRead("R7 no side effect", 12'h10C, 32'h05);
  endtask

  task automatic testPriority();
    @(negedge clk);
    fwAddr = 12'h10C; fwWrData = 32'hFF; fwWrEn = 1'b1;
    ioAddr = 8'h60; ioRdEn = 1'b1;
    @(negedge clk);
    fwWrEn = 1'b0; ioRdEn = 1'b0;
    fwRead("R12 read vs fw write", 12'h10C, 32'hFE);
    @(negedge clk);
    fwAddr = 12'h10C; fwWrData = 32'h00; fwWrEn = 1'b1;
    ioAddr = 8'h64; ioWrData = 8'h33; ioWrEn = 1'b1;
    @(negedge clk);
    fwWrEn = 1'b0; ioWrEn = 1'b0;
    fwRead("R12 write vs fw write", 12'h10C, 32'h0A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPortWrites();
    testOutputPath();
    testAuxIrq();
    testEmuIrq();
    testGate();
    testCmdRead();
    testPriority();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule